// File: doc/BRIEF.md
# Byte-Serial Cache Line Transfer Controller

This block is the single path between a processor's two caches and a RAM whose data port is one byte wide. The instruction cache asks for whole lines. The data cache asks for whole lines, which may first need a dirty victim written back, or for uncached I/O loads and stores of one, two or four bytes. The controller takes one request at a time and streams the bytes over the RAM port, one per cycle. It then returns the assembled result to the side that asked, as a one-cycle pulse.

Both request inputs are valid/ready streams. A request is taken on a clock edge where its valid and ready are both high. The requester holds valid and its fields steady until that edge. Ready is high only while the controller is idle and the run input is high. While the data side has valid high, instruction-side ready stays low. Responses are single-cycle valid pulses with no back-pressure, so the receiving cache must take them in that cycle. The RAM returns read data one cycle after the address. Addresses at or above `IO_BASE` (0x30000) are I/O and are never fetched as lines.

Top module: `mem_line_ctrl`

## Requirements
- R1: During and after reset no response pulse is high and `ram_wr` is 0. With run high and no request pending, both request readies are high.
- R2: An instruction line request reads the 16 bytes of its line in ascending address order, one per cycle, starting in the cycle after acceptance. The line is returned with the byte at offset k on bits [8k+7:8k]. `i_fill_valid` is high for exactly one cycle, 18 cycles after the accepting edge.
- R3: When both sides present valid in the same cycle, only the data side is accepted. The instruction request is taken after the data transaction finishes.
- R4: While `run` is low, no byte is issued and the transaction holds its position. The response arrives later by exactly the number of held cycles, and its data is unchanged.
- R5: A data line request with `d_req_dirty` set first writes the 16 victim bytes to the victim line, lowest address first, with `ram_wr` = 1 (1 means write, 0 means read). The 16 refill reads follow. The response comes 34 cycles after acceptance.
- R6: A clean data line request below `IO_BASE` behaves like an instruction fill but pulses `d_fill_valid`. Its `d_req_rd` value has no effect on the RAM traffic.
- R7: A data request at or above `IO_BASE` transfers only the byte count given by `d_req_size`, at consecutive addresses from the request address. The size codes are 01 for 1 byte, 10 for 2 bytes, 11 for 4 bytes, and 00 for 1 byte.
- R8: An I/O read (`d_req_rd` = 1) returns the bytes in `d_io_rdata`, with the lowest address on bits [7:0] and every byte beyond the count set to zero. `d_io_rvalid` is high for one cycle, n+2 cycles after acceptance.
- R9: An I/O write (`d_req_rd` = 0) writes the low n bytes of `d_req_wdata`, starting with bits [7:0], and pulses `d_io_wdone` n+1 cycles after acceptance. While `io_full` is high, no I/O byte is written and the write waits.
- R10: A `flush` seen with `run` high during an instruction fill ends the fill without an `i_fill_valid` pulse. A `flush` during a data write-back leaves it and its refill unchanged.
- R11: At most one response pulse is high in any cycle, and both readies are low while a transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Global enable; when low, all progress holds |
| flush | input | 1 | Misprediction clear; cancels an instruction fill |
| io_full | input | 1 | I/O sink cannot take a byte; stalls I/O writes |
| i_req_valid | input | 1 | Instruction line request valid |
| i_req_ready | output | 1 | Instruction request accepted on this edge if valid |
| i_req_line | input | 28 | Instruction line address (address bits 31:4) |
| i_fill_valid | output | 1 | One-cycle pulse: instruction line ready |
| i_fill_data | output | 128 | Assembled line, byte k at bits 8k+7:8k |
| d_req_valid | input | 1 | Data request valid |
| d_req_ready | output | 1 | Data request accepted on this edge if valid |
| d_req_addr | input | 32 | Data byte address; line or I/O chosen by value |
| d_req_rd | input | 1 | 1 = read, 0 = write (used for I/O only) |
| d_req_size | input | 2 | I/O byte count code |
| d_req_wdata | input | 32 | I/O store data, low-aligned |
| d_req_dirty | input | 1 | Victim line must be written back first |
| d_req_victim | input | 28 | Victim line address |
| d_req_victim_data | input | 128 | Victim line contents |
| d_fill_valid | output | 1 | One-cycle pulse: data line ready |
| d_fill_data | output | 128 | Assembled data line |
| d_io_rvalid | output | 1 | One-cycle pulse: I/O load data ready |
| d_io_rdata | output | 32 | I/O load data, low-aligned, zero-extended |
| d_io_wdone | output | 1 | One-cycle pulse: I/O store finished |
| ram_addr | output | 32 | RAM byte address |
| ram_wr | output | 1 | RAM direction: 1 write, 0 read |
| ram_dout | output | 8 | Byte to RAM |
| ram_din | input | 8 | Byte from RAM, one cycle after address |

## Verification
Line fills are swept over many line addresses, some at both ends of the small RAM model and one just below the I/O threshold. Each fill is checked byte by byte against an address-derived pattern, which exposes swapped, shifted or off-by-one byte positions from the read latency. I/O loads and stores are swept over every size code and all four byte offsets, which separates the count decode, zero-extension and store byte order. Simultaneous requests, run stalls, io_full stalls and flushes at fixed cycles separate priority, holding and abort behaviour by their exact response latency.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_RD,
    ST_FIN,
    ST_IOWR
  } seq_st_t;

  typedef enum logic [1:0] {
    JOB_IFILL,
    JOB_DFILL,
    JOB_IORD,
    JOB_IOWR
  } job_t;

  // size code to byte count: 01 -> 1, 10 -> 2, 11 -> 4, 00 -> 1
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b10:   return 3'd2;
      2'b11:   return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/mlc_arb.sv
module mlc_arb (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic run,
  input  logic flush,
  input  logic i_valid,
  input  logic d_valid,
  output logic i_ready,
  output logic d_ready,
  output logic i_fire,
  output logic d_fire
);

  // data side wins whenever it is present
  assign d_ready = idle & run;
  assign i_ready = idle & run & ~flush & ~d_valid;
  assign d_fire  = d_ready & d_valid;
  assign i_fire  = i_ready & i_valid;

  a_r3_data_first: assert property (@(posedge clk) disable iff (rst)
    i_fire |-> !d_valid);

  a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
    (i_ready || d_ready) |-> idle);

endmodule

// File: rtl/mlc_linebuf.sv
module mlc_linebuf #(
  parameter int LINE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_en,
  input  logic [LINE_W-1:0]        cap_idx,
  input  logic [7:0]               byte_in,
  input  logic [2:0]               io_n,
  output logic [8*(1<<LINE_W)-1:0] line_out,
  output logic [31:0]              word_out
);

  localparam int LINE_BYTES = 1 << LINE_W;

  logic [LINE_BYTES-1:0][7:0] bytes_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bytes_q <= '0;
    end else if (cap_en) begin
      bytes_q[cap_idx] <= byte_in;
    end
  end

  assign line_out = bytes_q;

  for (genvar j = 0; j < 4; j++) begin : g_word
    assign word_out[8*j +: 8] = (3'(j) < io_n) ? bytes_q[j] : 8'h00;
  end

endmodule

// File: rtl/mlc_seq.sv
module mlc_seq
  import mlc_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          LINE_W  = 4,
  parameter logic [31:0] IO_BASE = 32'h0003_0000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic                     flush,
  input  logic                     io_full,
  input  logic                     i_fire,
  input  logic [ADDR_W-LINE_W-1:0] i_line,
  input  logic                     d_fire,
  input  logic [ADDR_W-1:0]        d_addr,
  input  logic                     d_rd,
  input  logic [1:0]               d_size,
  input  logic [31:0]              d_wdata,
  input  logic                     d_dirty,
  input  logic [ADDR_W-LINE_W-1:0] d_victim,
  input  logic [8*(1<<LINE_W)-1:0] d_victim_data,
  output logic                     idle,
  output logic [ADDR_W-1:0]        ram_addr,
  output logic                     ram_wr,
  output logic [7:0]               ram_dout,
  output logic                     cap_en,
  output logic [LINE_W-1:0]        cap_idx,
  output logic [2:0]               io_n,
  output logic                     i_done,
  output logic                     d_done,
  output logic                     io_rdone,
  output logic                     io_wdone
);

  localparam int LINE_BYTES = 1 << LINE_W;
  localparam int LINE_BITS  = 8 * LINE_BYTES;
  localparam int TAG_W      = ADDR_W - LINE_W;

  seq_st_t            st;
  job_t               job;
  logic [LINE_W-1:0]  cnt;
  logic [TAG_W-1:0]   base_line;
  logic [TAG_W-1:0]   wb_line;
  logic [LINE_BITS-1:0] wb_data;
  logic [ADDR_W-1:0]  io_addr;
  logic [2:0]         io_n_q;
  logic [31:0]        wdata_q;
  logic               cap_pend;
  logic [LINE_W-1:0]  cap_idx_q;
  logic               i_done_q, d_done_q, io_rdone_q, io_wdone_q;

  logic               d_is_io;
  logic [LINE_W-1:0]  last_cnt;
  logic               abort;
  logic               issue;

  assign d_is_io  = (d_addr >= ADDR_W'(IO_BASE));
  assign last_cnt = (job == JOB_IORD) ? LINE_W'(io_n_q - 3'd1) : '1;
  assign abort    = run & flush & (job == JOB_IFILL) &
                    ((st == ST_RD) | (st == ST_FIN));
  assign issue    = run & (st == ST_RD) & ~abort;

  assign idle     = (st == ST_IDLE);
  assign io_n     = io_n_q;
  assign cap_en   = cap_pend;
  assign cap_idx  = cap_idx_q;
  assign i_done   = i_done_q;
  assign d_done   = d_done_q;
  assign io_rdone = io_rdone_q;
  assign io_wdone = io_wdone_q;

  // RAM side drive: convert request direction to RAM polarity (1 = write)
  always_comb begin
    ram_addr = '0;
    ram_dout = 8'h00;
    ram_wr   = 1'b0;
    case (st)
      ST_WB: begin
        ram_addr = {wb_line, cnt};
        ram_dout = wb_data[{cnt, 3'b000} +: 8];
        ram_wr   = run;
      end
      ST_RD: begin
        ram_addr = (job == JOB_IORD) ? io_addr + ADDR_W'(cnt) : {base_line, cnt};
      end
      ST_IOWR: begin
        ram_addr = io_addr + ADDR_W'(cnt);
        ram_dout = wdata_q[{cnt[1:0], 3'b000} +: 8];
        ram_wr   = run & ~io_full;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      job        <= JOB_IFILL;
      cnt        <= '0;
      base_line  <= '0;
      wb_line    <= '0;
      wb_data    <= '0;
      io_addr    <= '0;
      io_n_q     <= 3'd1;
      wdata_q    <= '0;
      cap_pend   <= 1'b0;
      cap_idx_q  <= '0;
      i_done_q   <= 1'b0;
      d_done_q   <= 1'b0;
      io_rdone_q <= 1'b0;
      io_wdone_q <= 1'b0;
    end else begin
      i_done_q   <= 1'b0;
      d_done_q   <= 1'b0;
      io_rdone_q <= 1'b0;
      io_wdone_q <= 1'b0;
      // the RAM answers one cycle after the address, whatever run does
      cap_pend   <= issue;
      cap_idx_q  <= cnt;
      if (run) begin
        case (st)
          ST_IDLE: begin
            cnt <= '0;
            if (d_fire) begin
              base_line <= d_addr[ADDR_W-1:LINE_W];
              io_addr   <= d_addr;
              io_n_q    <= size_bytes(d_size);
              wdata_q   <= d_wdata;
              wb_line   <= d_victim;
              wb_data   <= d_victim_data;
              if (d_is_io) begin
                job <= d_rd ? JOB_IORD : JOB_IOWR;
                st  <= d_rd ? ST_RD : ST_IOWR;
              end else begin
                job <= JOB_DFILL;
                st  <= d_dirty ? ST_WB : ST_RD;
              end
            end else if (i_fire) begin
              job       <= JOB_IFILL;
              base_line <= i_line;
              st        <= ST_RD;
            end
          end
          ST_WB: begin
            if (cnt == '1) begin
              cnt <= '0;
              st  <= ST_RD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_RD: begin
            if (abort) begin
              cnt <= '0;
              st  <= ST_IDLE;
            end else if (cnt == last_cnt) begin
              cnt <= '0;
              st  <= ST_FIN;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_FIN: begin
            st <= ST_IDLE;
            if (!abort) begin
              case (job)
                JOB_IFILL: i_done_q   <= 1'b1;
                JOB_DFILL: d_done_q   <= 1'b1;
                JOB_IORD:  io_rdone_q <= 1'b1;
                default:   ;
              endcase
            end
          end
          ST_IOWR: begin
            if (!io_full) begin
              if (cnt == LINE_W'(io_n_q - 3'd1)) begin
                cnt        <= '0;
                st         <= ST_IDLE;
                io_wdone_q <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(st) && $stable(cnt));

  a_r9_full_stalls_io: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IOWR && io_full) |=> (st == ST_IOWR) && $stable(cnt));

  a_r5_no_wb_after_read: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD) |=> (st != ST_WB));

  a_r10_abort_silent: assert property (@(posedge clk) disable iff (rst)
    abort |=> (st == ST_IDLE) && !i_done_q);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0({i_done_q, d_done_q, io_rdone_q, io_wdone_q}));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD) |-> (cnt <= last_cnt));

endmodule

// File: rtl/mem_line_ctrl.sv
module mem_line_ctrl #(
  parameter int          ADDR_W  = 32,
  parameter int          LINE_W  = 4,
  parameter logic [31:0] IO_BASE = 32'h0003_0000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  input  logic                         flush,
  input  logic                         io_full,
  input  logic                         i_req_valid,
  output logic                         i_req_ready,
  input  logic [ADDR_W-LINE_W-1:0]     i_req_line,
  output logic                         i_fill_valid,
  output logic [8*(1<<LINE_W)-1:0]     i_fill_data,
  input  logic                         d_req_valid,
  output logic                         d_req_ready,
  input  logic [ADDR_W-1:0]            d_req_addr,
  input  logic                         d_req_rd,
  input  logic [1:0]                   d_req_size,
  input  logic [31:0]                  d_req_wdata,
  input  logic                         d_req_dirty,
  input  logic [ADDR_W-LINE_W-1:0]     d_req_victim,
  input  logic [8*(1<<LINE_W)-1:0]     d_req_victim_data,
  output logic                         d_fill_valid,
  output logic [8*(1<<LINE_W)-1:0]     d_fill_data,
  output logic                         d_io_rvalid,
  output logic [31:0]                  d_io_rdata,
  output logic                         d_io_wdone,
  output logic [ADDR_W-1:0]            ram_addr,
  output logic                         ram_wr,
  output logic [7:0]                   ram_dout,
  input  logic [7:0]                   ram_din
);

  localparam int LINE_BITS = 8 * (1 << LINE_W);

  logic                 idle;
  logic                 i_fire, d_fire;
  logic                 cap_en;
  logic [LINE_W-1:0]    cap_idx;
  logic [2:0]           io_n;
  logic [LINE_BITS-1:0] line_w;

  mlc_arb u_arb (
    .clk     (clk),
    .rst     (rst),
    .idle    (idle),
    .run     (run),
    .flush   (flush),
    .i_valid (i_req_valid),
    .d_valid (d_req_valid),
    .i_ready (i_req_ready),
    .d_ready (d_req_ready),
    .i_fire  (i_fire),
    .d_fire  (d_fire)
  );

  mlc_seq #(
    .ADDR_W  (ADDR_W),
    .LINE_W  (LINE_W),
    .IO_BASE (IO_BASE)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .run           (run),
    .flush         (flush),
    .io_full       (io_full),
    .i_fire        (i_fire),
    .i_line        (i_req_line),
    .d_fire        (d_fire),
    .d_addr        (d_req_addr),
    .d_rd          (d_req_rd),
    .d_size        (d_req_size),
    .d_wdata       (d_req_wdata),
    .d_dirty       (d_req_dirty),
    .d_victim      (d_req_victim),
    .d_victim_data (d_req_victim_data),
    .idle          (idle),
    .ram_addr      (ram_addr),
    .ram_wr        (ram_wr),
    .ram_dout      (ram_dout),
    .cap_en        (cap_en),
    .cap_idx       (cap_idx),
    .io_n          (io_n),
    .i_done        (i_fill_valid),
    .d_done        (d_fill_valid),
    .io_rdone      (d_io_rvalid),
    .io_wdone      (d_io_wdone)
  );

  mlc_linebuf #(
    .LINE_W (LINE_W)
  ) u_buf (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .byte_in  (ram_din),
    .io_n     (io_n),
    .line_out (line_w),
    .word_out (d_io_rdata)
  );

  assign i_fill_data = line_w;
  assign d_fill_data = line_w;

endmodule

// File: tb/sim_mem_line_ctrl.sv
module sim_mem_line_ctrl;

  logic         clk = 1'b0;
  logic         rst, run, flush, io_full;
  logic         i_req_valid, i_req_ready;
  logic [27:0]  i_req_line;
  logic         i_fill_valid;
  logic [127:0] i_fill_data;
  logic         d_req_valid, d_req_ready, d_req_rd, d_req_dirty;
  logic [31:0]  d_req_addr, d_req_wdata;
  logic [1:0]   d_req_size;
  logic [27:0]  d_req_victim;
  logic [127:0] d_req_victim_data;
  logic         d_fill_valid, d_io_rvalid, d_io_wdone;
  logic [127:0] d_fill_data;
  logic [31:0]  d_io_rdata;
  logic [31:0]  ram_addr;
  logic         ram_wr;
  logic [7:0]   ram_dout, ram_din;

  always #2 clk = ~clk;

  mem_line_ctrl u0 (.*);

  int n_chk = 0;
  int n_err = 0;
  int w_lat;
  bit w_ok;
  bit w_busy;
  logic [127:0] got_line;
  logic [31:0]  got_word;

  logic [7:0] mem [0:4095];

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'((a[11:0] * 12'd29) + {3'b000, a[11:3]} + 12'd5);
  endfunction

  function automatic logic [127:0] exp_line(input logic [31:0] base);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = pat(base + 32'(k));
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(32'(i));
    end else if (ram_wr) begin
      mem[ram_addr[11:0]] <= ram_dout;
    end
    ram_din <= mem[ram_addr[11:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // kind: 0 instr fill, 1 data fill, 2 io read, 3 io write
  task automatic watch(input int kind, input bit wb, input logic [31:0] wbase,
                       input logic [31:0] base, input int nb, input bit sched,
                       input int maxc);
    logic [3:0] p;
    int rc;
    w_lat = -1; w_ok = 1'b1; w_busy = 1'b1;
    for (int c = 1; c <= maxc; c++) begin
      p = {i_fill_valid, d_fill_valid, d_io_rvalid, d_io_wdone};
      if ($countones(p) > 1) w_ok = 1'b0;
      if (p != 4'b0000) begin
        if (!p[3-kind]) w_ok = 1'b0;
        got_line = kind == 0 ? i_fill_data : d_fill_data;
        got_word = d_io_rdata;
        w_lat = c;
        break;
      end
      if (c == 2 && (i_req_ready || d_req_ready)) w_busy = 1'b0;
      if (sched) begin
        rc = wb ? c - 16 : c;
        if (wb && c <= 16) begin
          if (!(ram_wr && ram_addr == wbase + 32'(c - 1))) w_ok = 1'b0;
        end else if (kind == 3) begin
          if (c <= nb && !(ram_wr && ram_addr == base + 32'(c - 1))) w_ok = 1'b0;
        end else if (rc >= 1 && rc <= nb) begin
          if (!(!ram_wr && ram_addr == base + 32'(rc - 1))) w_ok = 1'b0;
        end else if (ram_wr) begin
          w_ok = 1'b0;
        end
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic send_i(input logic [27:0] line);
    @(negedge clk);
    i_req_line = line; i_req_valid = 1'b1;
    @(posedge clk); #1;
    i_req_valid = 1'b0;
  endtask

  task automatic send_d(input logic [31:0] a, input bit rd, input logic [1:0] sz,
                        input logic [31:0] wd, input bit dirty,
                        input logic [27:0] vic, input logic [127:0] vdat);
    @(negedge clk);
    d_req_addr = a; d_req_rd = rd; d_req_size = sz; d_req_wdata = wd;
    d_req_dirty = dirty; d_req_victim = vic; d_req_victim_data = vdat;
    d_req_valid = 1'b1;
    @(posedge clk); #1;
    d_req_valid = 1'b0;
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    logic [127:0] vd;
    logic [31:0]  a;
    int nb;
    rst = 1'b1; run = 1'b1; flush = 1'b0; io_full = 1'b0;
    i_req_valid = 1'b0; i_req_line = '0;
    d_req_valid = 1'b0; d_req_addr = '0; d_req_rd = 1'b1; d_req_size = 2'b11;
    d_req_wdata = '0; d_req_dirty = 1'b0; d_req_victim = '0; d_req_victim_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(!ram_wr && !i_fill_valid && !d_fill_valid && !d_io_rvalid && !d_io_wdone,
        "R1", "outputs in reset", {ram_wr, i_fill_valid, d_fill_valid}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(i_req_ready && d_req_ready && !ram_wr, "R1", "idle readies",
        {i_req_ready, d_req_ready, ram_wr}, 3'b110);

    // R2: instruction fill sweep over lines
    for (int l = 0; l < 12; l++) begin
      logic [27:0] ln;
      ln = (l < 10) ? 28'(l * 3) : 28'(250 + l);
      send_i(ln);
      watch(0, 0, 0, {ln, 4'h0}, 16, 1, 60);
      chk(w_ok && w_lat == 18, "R2", "ifill schedule/latency", 128'(w_lat), 18);
      chk(got_line == exp_line({ln, 4'h0}), "R2", "ifill data", got_line, exp_line({ln, 4'h0}));
      chk(w_busy, "R11", "readies low while busy", 0, 0);
    end

    // R6: clean data fills, both rd values, and just below the I/O threshold
    for (int l = 0; l < 6; l++) begin
      a = (l == 5) ? 32'h0002_FFFF : 32'(l * 16 * 7 + 5);
      send_d(a, l[0], 2'b11, 0, 0, 0, 0);
      watch(1, 0, 0, {a[31:4], 4'h0}, 16, 1, 60);
      chk(w_ok && w_lat == 18, "R6", "dfill schedule/latency", 128'(w_lat), 18);
      chk(got_line == exp_line({a[31:4], 4'h0}), "R6", "dfill data", got_line,
          exp_line({a[31:4], 4'h0}));
    end

    // R5: dirty write-back then refill
    for (int l = 0; l < 3; l++) begin
      logic [27:0] vl;
      vl = 28'(100 + l);
      for (int k = 0; k < 16; k++) vd[8*k +: 8] = 8'(8'hA0 + k * 3 + l);
      send_d({28'(120 + l), 4'h4}, 1, 2'b11, 0, 1, vl, vd);
      watch(1, 1, {vl, 4'h0}, {28'(120 + l), 4'h0}, 16, 1, 80);
      chk(w_ok && w_lat == 34, "R5", "writeback order/latency", 128'(w_lat), 34);
      chk(got_line == exp_line({28'(120 + l), 4'h0}), "R5", "refill data", got_line,
          exp_line({28'(120 + l), 4'h0}));
      for (int k = 0; k < 16; k++) begin
        chk(mem[12'({vl, 4'h0}) + 12'(k)] == vd[8*k +: 8], "R5", "victim byte in RAM",
            mem[12'({vl, 4'h0}) + 12'(k)], vd[8*k +: 8]);
      end
    end

    // R3: simultaneous requests, data side first
    @(negedge clk);
    i_req_line = 28'd40; i_req_valid = 1'b1;
    d_req_addr = 32'h0000_0330; d_req_rd = 1'b1; d_req_dirty = 1'b0; d_req_valid = 1'b1;
    #1;
    chk(!i_req_ready && d_req_ready, "R3", "ready under contention",
        {i_req_ready, d_req_ready}, 2'b01);
    @(posedge clk); #1;
    d_req_valid = 1'b0;
    watch(1, 0, 0, 32'h0000_0330, 16, 1, 60);
    chk(w_ok && w_lat == 18, "R3", "data served first", 128'(w_lat), 18);
    @(posedge clk); #1;
    i_req_valid = 1'b0;
    watch(0, 0, 0, 32'h0000_0280, 16, 1, 60);
    chk(w_ok && w_lat == 18, "R3", "instr served after", 128'(w_lat), 18);
    chk(got_line == exp_line(32'h280), "R3", "instr data after", got_line, exp_line(32'h280));

    // R7, R8: I/O reads over all sizes and offsets
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 4; o++) begin
        logic [31:0] ew;
        nb = (s == 2) ? 2 : (s == 3) ? 4 : 1;
        a = 32'h0003_0040 + 32'(o);
        ew = '0;
        for (int k = 0; k < 4; k++) if (k < nb) ew[8*k +: 8] = pat(a + 32'(k));
        send_d(a, 1, 2'(s), 0, 0, 0, 0);
        watch(2, 0, 0, a, nb, 1, 30);
        chk(w_ok && w_lat == nb + 2, "R7", "io read bytes/latency", 128'(w_lat), 128'(nb + 2));
        chk(got_word == ew, "R8", "io read data", got_word, ew);
      end
    end

    // R9: I/O writes over all sizes and offsets
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 4; o++) begin
        logic [31:0] wd;
        nb = (s == 2) ? 2 : (s == 3) ? 4 : 1;
        a = 32'h0003_0800 + 32'(s * 8 + o);
        wd = 32'h1357_9BDF ^ 32'(s * 17 + o * 5);
        send_d(a, 0, 2'(s), wd, 0, 0, 0);
        watch(3, 0, 0, a, nb, 1, 30);
        chk(w_ok && w_lat == nb + 1, "R9", "io write bytes/latency", 128'(w_lat), 128'(nb + 1));
        for (int k = 0; k < nb; k++) begin
          chk(mem[a[11:0] + 12'(k)] == wd[8*k +: 8], "R9", "io byte in RAM",
              mem[a[11:0] + 12'(k)], wd[8*k +: 8]);
        end
      end
    end

    // R9: io_full holds an I/O write
    send_d(32'h0003_0900, 0, 2'b11, 32'hCAFE_F00D, 0, 0, 0);
    fork
      watch(3, 0, 0, 0, 4, 0, 40);
      begin
        repeat (2) @(negedge clk);
        io_full = 1'b1;
        for (int k = 0; k < 3; k++) begin
          #1;
          chk(!ram_wr, "R9", "no write while full", ram_wr, 0);
          @(negedge clk);
        end
        io_full = 1'b0;
      end
    join
    chk(w_ok && w_lat == 8, "R9", "io write stalled latency", 128'(w_lat), 8);
    chk(mem[12'h900] == 8'h0D && mem[12'h903] == 8'hCA, "R9", "stalled write data",
        {mem[12'h903], mem[12'h900]}, 16'hCA0D);

    // R4: run low in mid fill
    send_i(28'd77);
    fork
      watch(0, 0, 0, 0, 16, 0, 60);
      begin
        repeat (5) @(negedge clk);
        run = 1'b0;
        repeat (4) @(negedge clk);
        run = 1'b1;
      end
    join
    chk(w_ok && w_lat == 22, "R4", "held latency", 128'(w_lat), 22);
    chk(got_line == exp_line(32'h4D0), "R4", "held data", got_line, exp_line(32'h4D0));

    // R10: flush cancels an instruction fill
    send_i(28'd90);
    fork
      watch(0, 0, 0, 0, 16, 0, 40);
      begin
        repeat (4) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end
    join
    chk(w_lat == -1, "R10", "no pulse after flush", 128'(w_lat), 128'(-1));
    @(negedge clk);
    chk(i_req_ready && d_req_ready, "R10", "idle after flush", {i_req_ready, d_req_ready}, 2'b11);

    // R10: flush does not disturb a write-back
    for (int k = 0; k < 16; k++) vd[8*k +: 8] = 8'(8'h31 * (k + 1));
    send_d(32'h0000_0A00, 1, 2'b11, 0, 1, 28'd140, vd);
    fork
      watch(1, 1, 32'h0000_08C0, 32'h0000_0A00, 16, 1, 80);
      begin
        repeat (3) @(negedge clk);
        flush = 1'b1;
        repeat (2) @(negedge clk);
        flush = 1'b0;
      end
    join
    chk(w_ok && w_lat == 34, "R10", "writeback unaffected", 128'(w_lat), 34);
    chk(mem[12'h8C0] == vd[7:0] && mem[12'h8CF] == vd[127:120], "R10", "victim written",
        {mem[12'h8CF], mem[12'h8C0]}, {vd[127:120], vd[7:0]});

    finish_sim();
  end

endmodule